// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Unit

This unit sits beside the pipeline registers of a five-stage in-order pipeline and decides, for every cycle, where each of the two ALU source operands must come from. An operand can come from the register file, from the result parked in the execute/memory register, or from the result parked in the memory/writeback register. When both later stages hold a result for the same register, the younger one, in the execute/memory register, wins. Register zero is hard-wired and is never taken from a bypass path.

The unit also spots the one dependence that bypassing cannot resolve. This happens when the instruction now in execute is a load and the instruction right behind it, in decode, reads the register that the load will write. In that cycle the unit holds the program counter and the fetch/decode register, and it tells the decode/execute register to take a bubble whose control fields are all zero. On the next cycle the bubble is in execute, so the hazard has gone and the stall lasts exactly one cycle. The unit has no state: every output is a function of the present pipeline-register fields only.

Top module: `hazardUnit`

## Requirements
- R1: `fwdSelA` is `2'b10` (execute/memory result) whenever `exmemRegWrite` is 1, `exmemRd` is nonzero and `exmemRd` equals `idexRs`.
- R2: When the R1 condition is false, `fwdSelA` is `2'b01` (memory/writeback result) whenever `memwbRegWrite` is 1, `memwbRd` is nonzero and `memwbRd` equals `idexRs`. In every other case it is `2'b00` (register file).
- R3: When both the execute/memory and the memory/writeback conditions match the same source register, the select is `2'b10`.
- R4: A destination of register 0 never produces a forward. A stage with `Rd == 0` contributes nothing, even with its write flag set.
- R5: A stage whose write flag is 0 never produces a forward, even when its destination matches.
- R6: `fwdSelB` follows the rules of R1 to R5 with `idexRt` in place of `idexRs`, independently of `fwdSelA`.
- R7: Neither select ever takes the value `2'b11`.
- R8: When `idexMemRead` is 1 and `idexRt` equals `ifidRs` or `ifidRt`, then `pcWriteEn` is 0, `ifidWriteEn` is 0 and `idexBubble` is 1.
- R9: In every other case (no load in execute, or a load whose target is read by neither decode source) `pcWriteEn` and `ifidWriteEn` are 1 and `idexBubble` is 0. This includes the cycle after a stall, when the bubble occupies execute.
- R10: The outputs depend only on the present inputs and change in the same evaluation as the inputs, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ifidRs | input | REG_W | First source specifier of the instruction in decode |
| ifidRt | input | REG_W | Second source specifier of the instruction in decode |
| idexRs | input | REG_W | First source specifier of the instruction in execute |
| idexRt | input | REG_W | Second source specifier in execute; also the load target |
| idexMemRead | input | 1 | Instruction in execute is a load |
| exmemRegWrite | input | 1 | Execute/memory instruction writes a register |
| exmemRd | input | REG_W | Execute/memory destination register |
| memwbRegWrite | input | 1 | Memory/writeback instruction writes a register |
| memwbRd | input | REG_W | Memory/writeback destination register |
| fwdSelA | output | 2 | Source select for the first ALU operand |
| fwdSelB | output | 2 | Source select for the second ALU operand |
| pcWriteEn | output | 1 | Program counter update enable (0 during a stall) |
| ifidWriteEn | output | 1 | Fetch/decode register update enable (0 during a stall) |
| idexBubble | output | 1 | Zero the control fields entering decode/execute |

## Verification
Directed sequences cover the cases that separate the bypass rules: a single match in each later stage, a double match that only the age priority resolves, register 0 with its write flag set, and a matching destination with its write flag clear. Load sequences set a stalling match on each decode source in turn. They then try a load with no match and a non-load with a match, which shows that the stall depends on both the load flag and the compare. A bubble cycle after a stall checks that the stall lasts a single cycle. Random patterns draw register numbers from a small range, so that single, double and zero-register collisions happen often. Each pattern is compared with a bench model of the rules.

// File: rtl/hazardPkg.sv
package hazardPkg;

  // Number of ALU source operands (rs, rt)
  localparam int SRC_COUNT = 2;

  // Operand source codes
  localparam logic [1:0] SEL_REGFILE = 2'b00;
  localparam logic [1:0] SEL_MEMWB   = 2'b01;
  localparam logic [1:0] SEL_EXMEM   = 2'b10;

  // Strobes from control towards the pipeline edge
  typedef struct packed {
    logic [SRC_COUNT-1:0][1:0] opSel;
    logic                      holdFront;
    logic                      bubble;
  } strobesT;

endpackage

// File: rtl/hazardDatapath.sv
module hazardDatapath
  import hazardPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [SRC_COUNT-1:0][REG_W-1:0] ifidSrc,
  input  logic [SRC_COUNT-1:0][REG_W-1:0] idexSrc,
  input  logic [REG_W-1:0]                idexLoadDst,
  input  logic                            exmemRegWrite,
  input  logic [REG_W-1:0]                exmemRd,
  input  logic                            memwbRegWrite,
  input  logic [REG_W-1:0]                memwbRd,
  output logic [SRC_COUNT-1:0]            exHit,
  output logic [SRC_COUNT-1:0]            memHit,
  output logic [SRC_COUNT-1:0]            useHit
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exLive;
  logic memLive;

  // A stage can only bypass if it writes a real register
  assign exLive  = exmemRegWrite && (exmemRd != ZERO_REG);
  assign memLive = memwbRegWrite && (memwbRd != ZERO_REG);

  for (genvar i = 0; i < SRC_COUNT; i++) begin : g_cmp
    assign exHit[i]  = exLive  && (exmemRd == idexSrc[i]);
    assign memHit[i] = memLive && (memwbRd == idexSrc[i]);
    assign useHit[i] = (idexLoadDst == ifidSrc[i]);
  end

endmodule

// File: rtl/hazardControl.sv
module hazardControl
  import hazardPkg::*;
(
  input  logic [SRC_COUNT-1:0] exHit,
  input  logic [SRC_COUNT-1:0] memHit,
  input  logic [SRC_COUNT-1:0] useHit,
  input  logic                 loadInEx,
  output strobesT              strobes
);

  logic stallReq;

  assign stallReq = loadInEx && (|useHit);

  always_comb begin
    strobes = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      // younger result takes priority
      if (exHit[i])       strobes.opSel[i] = SEL_EXMEM;
      else if (memHit[i]) strobes.opSel[i] = SEL_MEMWB;
      else                strobes.opSel[i] = SEL_REGFILE;
    end
    strobes.holdFront = stallReq;
    strobes.bubble    = stallReq;
  end

endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hazardPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ifidRs,
  input  logic [REG_W-1:0] ifidRt,
  input  logic [REG_W-1:0] idexRs,
  input  logic [REG_W-1:0] idexRt,
  input  logic             idexMemRead,
  input  logic             exmemRegWrite,
  input  logic [REG_W-1:0] exmemRd,
  input  logic             memwbRegWrite,
  input  logic [REG_W-1:0] memwbRd,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             pcWriteEn,
  output logic             ifidWriteEn,
  output logic             idexBubble
);

  logic [SRC_COUNT-1:0][REG_W-1:0] ifidSrc;
  logic [SRC_COUNT-1:0][REG_W-1:0] idexSrc;
  logic [SRC_COUNT-1:0]            exHit;
  logic [SRC_COUNT-1:0]            memHit;
  logic [SRC_COUNT-1:0]            useHit;
  strobesT                         strobes;

  assign ifidSrc = {ifidRt, ifidRs};
  assign idexSrc = {idexRt, idexRs};

  hazardDatapath #(.REG_W(REG_W)) dp_i (
    .ifidSrc       (ifidSrc),
    .idexSrc       (idexSrc),
    .idexLoadDst   (idexRt),
    .exmemRegWrite (exmemRegWrite),
    .exmemRd       (exmemRd),
    .memwbRegWrite (memwbRegWrite),
    .memwbRd       (memwbRd),
    .exHit         (exHit),
    .memHit        (memHit),
    .useHit        (useHit)
  );

  hazardControl ctl_i (
    .exHit    (exHit),
    .memHit   (memHit),
    .useHit   (useHit),
    .loadInEx (idexMemRead),
    .strobes  (strobes)
  );

  assign fwdSelA     = strobes.opSel[0];
  assign fwdSelB     = strobes.opSel[1];
  assign pcWriteEn   = !strobes.holdFront;
  assign ifidWriteEn = !strobes.holdFront;
  assign idexBubble  = strobes.bubble;

endmodule

// File: rtl/hazardUnitChk.sv
module hazardUnitChk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] ifidRs,
  input logic [REG_W-1:0] ifidRt,
  input logic [REG_W-1:0] idexRs,
  input logic [REG_W-1:0] idexRt,
  input logic             idexMemRead,
  input logic             exmemRegWrite,
  input logic [REG_W-1:0] exmemRd,
  input logic             memwbRegWrite,
  input logic [REG_W-1:0] memwbRd,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB,
  input logic             pcWriteEn,
  input logic             ifidWriteEn,
  input logic             idexBubble
);

  always_comb begin
    // R1
    ex_fwd_a_chk: assert (!(exmemRegWrite && exmemRd != '0 && exmemRd == idexRs) || fwdSelA == 2'b10);
    // R6
    ex_fwd_b_chk: assert (!(exmemRegWrite && exmemRd != '0 && exmemRd == idexRt) || fwdSelB == 2'b10);
    // R4
    zero_reg_chk: assert (!(exmemRd == '0 && memwbRd == '0) || (fwdSelA == 2'b00 && fwdSelB == 2'b00));
    // R5
    no_write_chk: assert (!(!exmemRegWrite && !memwbRegWrite) || (fwdSelA == 2'b00 && fwdSelB == 2'b00));
    // R7
    no_code3_chk: assert (fwdSelA != 2'b11 && fwdSelB != 2'b11);
    // R8
    stall_chk: assert (!(idexMemRead && (idexRt == ifidRs || idexRt == ifidRt)) || (!pcWriteEn && !ifidWriteEn && idexBubble));
    // R9
    no_stall_chk: assert (idexMemRead || (pcWriteEn && ifidWriteEn && !idexBubble));
  end

endmodule

bind hazardUnit hazardUnitChk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/hazardUnit_tb_top.sv
`timescale 1ns/1ps
module hazardUnit_tb_top;

  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0] ifidRs, ifidRt, idexRs, idexRt, exmemRd, memwbRd;
  logic idexMemRead, exmemRegWrite, memwbRegWrite;
  logic [1:0] fwdSelA, fwdSelB;
  logic pcWriteEn, ifidWriteEn, idexBubble;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  hazardUnit #(.REG_W(REG_W)) dut_i (.*);

  function automatic logic [1:0] expSel(logic [REG_W-1:0] src);
    if (exmemRegWrite && exmemRd != 0 && exmemRd == src) return 2'b10;
    if (memwbRegWrite && memwbRd != 0 && memwbRd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic expStall();
    return idexMemRead && (idexRt == ifidRs || idexRt == ifidRt);
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive(logic [REG_W-1:0] fRs, fRt, eRs, eRt, logic ld,
                       logic exW, logic [REG_W-1:0] exD, logic mwW, logic [REG_W-1:0] mwD);
    @(negedge clk);
    ifidRs = fRs; ifidRt = fRt; idexRs = eRs; idexRt = eRt; idexMemRead = ld;
    exmemRegWrite = exW; exmemRd = exD; memwbRegWrite = mwW; memwbRd = mwD;
    #1;
  endtask

  task automatic chkStall(string req, logic s);
    chk({req, " pcWriteEn"}, {1'b0, pcWriteEn}, {1'b0, !s});
    chk({req, " ifidWriteEn"}, {1'b0, ifidWriteEn}, {1'b0, !s});
    chk({req, " idexBubble"}, {1'b0, idexBubble}, {1'b0, s});
  endtask

  initial begin
    ifidRs = 0; ifidRt = 0; idexRs = 0; idexRt = 0; idexMemRead = 0;
    exmemRegWrite = 0; exmemRd = 0; memwbRegWrite = 0; memwbRd = 0;
    void'($urandom(32'd375));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // reset state, all fields zero
    chk("R9 reset selA", fwdSelA, 2'b00);
    chk("R9 reset selB", fwdSelB, 2'b00);
    chkStall("R9 reset", 1'b0);

    // R1 single EX/MEM match on rs
    drive(1, 2, 3, 4, 0, 1, 3, 0, 0);
    chk("R1 ex match A", fwdSelA, 2'b10);
    chk("R6 B untouched", fwdSelB, 2'b00);
    // R2 single MEM/WB match on rs
    drive(1, 2, 3, 4, 0, 1, 7, 1, 3);
    chk("R2 mem match A", fwdSelA, 2'b01);
    // R3 both match
    drive(1, 2, 5, 5, 0, 1, 5, 1, 5);
    chk("R3 priority A", fwdSelA, 2'b10);
    chk("R3 priority B", fwdSelB, 2'b10);
    // R4 register zero with write set
    drive(1, 2, 0, 0, 0, 1, 0, 1, 0);
    chk("R4 zero A", fwdSelA, 2'b00);
    chk("R4 zero B", fwdSelB, 2'b00);
    // R4 EX zero falls through to MEM? no: MEM also needs nonzero
    drive(1, 2, 0, 6, 0, 1, 0, 1, 6);
    chk("R4 zero A mem", fwdSelA, 2'b00);
    chk("R6 mem match B", fwdSelB, 2'b01);
    // R5 write flags clear
    drive(1, 2, 9, 9, 0, 0, 9, 0, 9);
    chk("R5 noWrite A", fwdSelA, 2'b00);
    chk("R5 noWrite B", fwdSelB, 2'b00);
    // R5 EX not writing, MEM writing
    drive(1, 2, 9, 8, 0, 0, 9, 1, 9);
    chk("R5 ex off A", fwdSelA, 2'b01);
    // R6 B from EX, A from MEM
    drive(1, 2, 11, 12, 0, 1, 12, 1, 11);
    chk("R6 split A", fwdSelA, 2'b01);
    chk("R6 split B", fwdSelB, 2'b10);
    // R8 load-use on rs, then on rt
    drive(7, 2, 3, 7, 1, 0, 0, 0, 0);
    chkStall("R8 rs use", 1'b1);
    drive(1, 7, 3, 7, 1, 0, 0, 0, 0);
    chkStall("R8 rt use", 1'b1);
    // R9 bubble now in EX (load moved on), same decode instruction
    drive(1, 7, 0, 0, 0, 0, 0, 1, 7);
    chkStall("R9 after bubble", 1'b0);
    // R9 load without match; non-load with match
    drive(1, 2, 3, 7, 1, 0, 0, 0, 0);
    chkStall("R9 load no match", 1'b0);
    drive(7, 7, 3, 7, 0, 0, 0, 0, 0);
    chkStall("R9 no load", 1'b0);
    // R10 outputs follow inputs without a clock edge
    @(negedge clk);
    exmemRegWrite = 1; exmemRd = 4; idexRs = 4; #0.5;
    chk("R10 comb A", fwdSelA, 2'b10);
    idexRs = 5; #0.5;
    chk("R10 comb A drop", fwdSelA, 2'b00);

    // random patterns over a small register range
    for (int n = 0; n < 3000; n++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3));
      chk("R1 R2 R3 R7 rand A", fwdSelA, expSel(idexRs));
      chk("R6 rand B", fwdSelB, expSel(idexRt));
      chkStall("R8 R9 rand", expStall());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule